// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Flags

This block sits beside the timekeeping counters of a real-time clock. Each time the counters finish an update, it compares the current seconds, minutes and hours against three alarm bytes. A full match latches an alarm flag. The same update pulse latches an update-ended flag, and a tick from the periodic divider latches a periodic flag.

Software reads the three flags through one read port. The read returns the flags and clears all of them. Three enable inputs, driven from the clock's control register, select which flags can drive the interrupt line. The top bit of the read data is a summary bit that equals the interrupt line.

An alarm byte whose two top bits are both set acts as a wildcard and matches any value. The hour comparison is made on the full byte. In 12-hour mode the top bit of the hour is the PM bit, so an alarm for 2 AM never fires at 2 PM.

Top module: `rtc_alarm_flags`

## Requirements
- R1: After reset, the three alarm bytes are 0x00, all flags are clear, `flag_rdata` reads 0x00 and `irq` is low.
- R2: When `upd_done` is high at a clock edge, the update flag (read-data bit 4) is set from the next cycle on.
- R3: When `per_tick` is high at a clock edge, the periodic flag (read-data bit 6) is set from the next cycle on.
- R4: When `upd_done` is high at a clock edge and the seconds, minutes and hours inputs each equal their alarm byte, the alarm flag (read-data bit 5) is set from the next cycle on. When any field differs, the alarm flag is left unchanged. The alarm bytes are written through `alm_we` with `alm_sel` set to 0 for seconds, 1 for minutes and 2 for hours.
- R5: An alarm byte with bits 7 and 6 both set matches any value in its field.
- R6: The hour comparison covers all eight bits. A time and an alarm hour that differ only in bit 7 (the PM bit) do not set the alarm flag.
- R7: `irq` is high exactly when at least one flag is set together with its enable: periodic with `en_periodic`, alarm with `en_alarm`, update with `en_update`. Read-data bit 7 always equals `irq`, and read-data bits 3..0 are 0.
- R8: A clock edge with `flag_rd` high clears all three flags. `flag_rdata` shows the flags before the clear. A second read therefore returns 0x00, and `irq` falls after the read.
- R9: A flag event that arrives on the same edge as a read is kept, and the next read shows it.
- R10: A time that matches the alarm bytes while `upd_done` is low does not set the alarm flag.
- R11: Each flag is set even when its enable is low. While all enables are low, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_sec | input | DW | Current seconds |
| time_min | input | DW | Current minutes |
| time_hour | input | DW | Current hours; bit 7 is PM in 12-hour mode |
| alm_we | input | 1 | Alarm byte write strobe |
| alm_sel | input | 2 | Alarm byte select: 0 seconds, 1 minutes, 2 hours |
| alm_wdata | input | DW | Alarm byte write data |
| upd_done | input | 1 | Pulse at the end of a time update |
| per_tick | input | 1 | Periodic divider tick |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| flag_rd | input | 1 | Flag register read strobe (read clears) |
| flag_rdata | output | DW | {summary, periodic, alarm, update, 0000} |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets several corner cases:

- **Wildcard bytes.** A wildcard byte that is not exactly 0xC0 must still match. A design that tested only for 0xC0 would miss these alarms.
- **PM-only hour difference.** The bench uses hours that differ only in the PM bit. A design that masked that bit would raise a false alarm twelve hours early.
- **Read colliding with an event.** The bench issues a read on the same edge as a tick. A design that let the clear win would lose that interrupt without any sign.
- **Match without an update.** The bench holds a matching time with no update pulse. A design that compared on every cycle would set the flag with no update.

The bench also drives long random runs against a behavioural model, which exposes enable-gating and summary-bit errors in any combination.

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags #(
  parameter int DW   = 8,
  parameter int NALM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] time_sec,
  input  logic [DW-1:0] time_min,
  input  logic [DW-1:0] time_hour,
  input  logic          alm_we,
  input  logic [1:0]    alm_sel,
  input  logic [DW-1:0] alm_wdata,
  input  logic          upd_done,
  input  logic          per_tick,
  input  logic          en_periodic,
  input  logic          en_alarm,
  input  logic          en_update,
  input  logic          flag_rd,
  output logic [DW-1:0] flag_rdata,
  output logic          irq
);
  localparam int PADW = DW - 4;

  logic [DW-1:0]   alm [NALM];
  logic [DW-1:0]   tv  [NALM];
  logic [NALM-1:0] fmatch;
  logic            hit, pf, af, uf;

  assign tv[0] = time_sec;
  assign tv[1] = time_min;
  assign tv[2] = time_hour;

  for (genvar g = 0; g < NALM; g++) begin : g_cmp
    assign fmatch[g] = (alm[g][DW-1:DW-2] == 2'b11) || (alm[g] == tv[g]);
  end

  assign hit = upd_done && (&fmatch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NALM; i++) alm[i] <= '0;
    end else if (alm_we && (int'(alm_sel) < NALM)) begin
      alm[alm_sel] <= alm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf <= 1'b0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      pf <= per_tick | (pf & ~flag_rd);
      af <= hit      | (af & ~flag_rd);
      uf <= upd_done | (uf & ~flag_rd);
    end
  end

  assign irq        = (pf & en_periodic) | (af & en_alarm) | (uf & en_update);
  assign flag_rdata = {irq, pf, af, uf, {PADW{1'b0}}};

  p_uf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flag_rdata[4]);

  p_pf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> flag_rdata[6]);

  p_wild_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && alm[0][DW-1:DW-2] == 2'b11 && alm[1][DW-1:DW-2] == 2'b11
     && alm[2][DW-1:DW-2] == 2'b11) |=> flag_rdata[5]);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !upd_done && !per_tick) |=> (flag_rdata == '0 && !irq));

  p_af_needs_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rdata[5]) |-> $past(upd_done));

  p_no_enable_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_periodic && !en_alarm && !en_update) |-> !irq);
endmodule

// File: tb/test_rtc_alarm_flags.sv
`timescale 1ns/1ps
module test_rtc_alarm_flags;
  logic       clk = 0, rst_n = 0;
  logic [7:0] time_sec = 0, time_min = 0, time_hour = 0, alm_wdata = 0;
  logic       alm_we = 0, upd_done = 0, per_tick = 0, flag_rd = 0;
  logic [1:0] alm_sel = 0;
  logic       en_periodic = 0, en_alarm = 0, en_update = 0;
  logic [7:0] flag_rdata;
  logic       irq;

  int checks = 0, errors = 0;
  int m_alm[3];
  bit m_pf, m_af, m_uf;

  always #10 clk = ~clk;

  rtc_alarm_flags i_rtc_alarm_flags (
    .clk(clk), .rst_n(rst_n), .time_sec(time_sec), .time_min(time_min),
    .time_hour(time_hour), .alm_we(alm_we), .alm_sel(alm_sel),
    .alm_wdata(alm_wdata), .upd_done(upd_done), .per_tick(per_tick),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .flag_rd(flag_rd), .flag_rdata(flag_rdata), .irq(irq));

  function automatic bit fld_ok(int a, int t);
    return ((a & 8'hC0) == 8'hC0) || (a == t);
  endfunction

  function automatic bit exp_irq();
    return (m_pf && en_periodic) || (m_af && en_alarm) || (m_uf && en_update);
  endfunction

  function automatic logic [7:0] exp_rd();
    return {exp_irq(), m_pf, m_af, m_uf, 4'b0000};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit hit, n_pf, n_af, n_uf;
    hit  = upd_done && fld_ok(m_alm[0], time_sec) && fld_ok(m_alm[1], time_min)
           && fld_ok(m_alm[2], time_hour);
    n_pf = per_tick || (m_pf && !flag_rd);
    n_af = hit      || (m_af && !flag_rd);
    n_uf = upd_done || (m_uf && !flag_rd);
    @(posedge clk);
    #1;
    if (alm_we) m_alm[alm_sel] = alm_wdata;
    m_pf = n_pf; m_af = n_af; m_uf = n_uf;
    chk(tag, {irq, flag_rdata}, {exp_irq(), exp_rd()});
    alm_we = 0; upd_done = 0; per_tick = 0; flag_rd = 0;
  endtask

  task automatic wr_alm(int sel, int v);
    alm_we = 1; alm_sel = 2'(sel); alm_wdata = 8'(v);
    step("R4 alarm write");
  endtask

  task automatic set_time(int h, int m, int s);
    time_hour = 8'(h); time_min = 8'(m); time_sec = 8'(s);
  endtask

  task automatic rd(string tag, logic [7:0] exp);
    chk(tag, flag_rdata, exp);
    flag_rd = 1;
    step(tag);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    m_alm = '{0, 0, 0};
    chk("R1 reset flags", flag_rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R1: alarm bytes reset to zero, so a 00:00:00 update matches
    set_time(0, 0, 0); upd_done = 1; step("R1");
    rd("R1 zero alarm match", 8'h30);

    // R4 R2 R11: exact match, enables off
    wr_alm(0, 8'h30); wr_alm(1, 8'h15); wr_alm(2, 8'h08);
    set_time(8'h08, 8'h15, 8'h30); upd_done = 1; step("R4");
    chk("R4 R2 R11 match no enables", {irq, flag_rdata}, 9'h030);
    rd("R8 read returns flags", 8'h30);
    rd("R8 second read zero", 8'h00);

    // R4: seconds mismatch
    set_time(8'h08, 8'h15, 8'h31); upd_done = 1; step("R4");
    rd("R4 mismatch only UF", 8'h10);

    // R5: wildcards that are not exactly 0xC0
    wr_alm(0, 8'hC0); wr_alm(1, 8'hC5);
    set_time(8'h08, 8'h42, 8'h17); upd_done = 1; step("R5");
    rd("R5 wildcard match", 8'h30);

    // R6: PM bit in hours
    wr_alm(2, 8'h82);
    set_time(8'h02, 8'h00, 8'h00); upd_done = 1; step("R6");
    rd("R6 AM vs PM no alarm", 8'h10);
    set_time(8'h82, 8'h00, 8'h00); upd_done = 1; step("R6");
    rd("R6 PM matches", 8'h30);

    // R10: matching time, no update pulse
    step("R10"); step("R10");
    chk("R10 no compare without update", flag_rdata, 8'h00);

    // R3 R7 R8: periodic path
    per_tick = 1; step("R3");
    chk("R3 PF set", flag_rdata, 8'h40);
    en_periodic = 1; #1;
    chk("R7 irq via periodic", {irq, flag_rdata}, 9'h1C0);
    rd("R8 read with irq", 8'hC0);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);

    // R9: event on the read edge is kept
    per_tick = 1; step("R9");
    flag_rd = 1; per_tick = 1; step("R9");
    chk("R9 tick kept across read", flag_rdata, 8'hC0);
    rd("R9 drain", 8'hC0);

    // R7: update flag without its enable
    en_periodic = 0; en_alarm = 1; upd_done = 1; set_time(1, 1, 1); step("R7");
    chk("R7 UF without UIE", {irq, flag_rdata}, 9'h010);
    en_update = 1; #1;
    chk("R7 UF with UIE", {irq, flag_rdata}, 9'h190);
    rd("R7 drain", 8'h90);

    // random run against the model
    for (int n = 0; n < 3000; n++) begin
      en_periodic = 1'($urandom); en_alarm = 1'($urandom); en_update = 1'($urandom);
      upd_done = ($urandom % 4) == 0;
      per_tick = ($urandom % 5) == 0;
      flag_rd  = ($urandom % 6) == 0;
      if (($urandom % 10) == 0) begin
        alm_we = 1; alm_sel = 2'($urandom % 3);
        alm_wdata = ($urandom % 3 == 0) ? 8'(8'hC0 | ($urandom % 64)) : 8'($urandom % 4);
      end
      set_time(($urandom % 2) ? 8'h80 | ($urandom % 4) : ($urandom % 4),
               $urandom % 4, $urandom % 4);
      step("R7 R8 model");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule